// File: doc/BRIEF.md
# Sector Cache Tag and Valid Controller

This block is the lookup and refill control of a direct-mapped cache in which a single tag covers a whole line, while each line is cut into four sub-blocks that each carry their own valid bit. Sharing one tag across a wide line keeps tag storage small. Because validity is tracked per sub-block, a miss only has to fetch the single missing sub-block instead of the whole line. A small data store, one word per sub-block, sits next to the tags so that a hit also returns data.

A requester presents an address with a valid strobe. One cycle after a lookup is accepted, the block reports hit or miss, plus the stored word on a hit. On a miss it raises a refill request carrying the tag, line and sub-block of the missing piece. It stalls further lookups until the memory side answers with a completion pulse and the fill word. The update is applied at that completion. If the line held a different tag, the new tag is installed and the line's other sub-blocks are invalidated. If the tag already matched, the sibling sub-blocks keep their state. The requester re-issues the lookup after the stall ends.

Top module: `sector_cache`

## Requirements
- R1: A synchronous active-high reset clears every sub-block valid bit and leaves lk_ready high, fill_req low and rsp_valid low. After reset every lookup misses.
- R2: The address splits as: bits [1:0] word offset (ignored), bits [3:2] sub-block index, bits [7:4] line index, bits [15:8] tag. Two addresses that differ only in the offset give the same result.
- R3: A lookup is accepted when lk_valid and lk_ready are both high. rsp_valid is high exactly in the following cycle. rsp_hit is high only if the stored tag of the line equals the address tag and the addressed sub-block is valid; a tag match alone is a miss.
- R4: On a hit, rsp_data equals the word delivered by the most recent refill of that sub-block.
- R5: On a miss, fill_req rises in the same cycle as the miss response, with fill_tag, fill_line and fill_sub equal to the address fields. These stay stable until fill_done is seen.
- R6: lk_ready is low while a refill is outstanding. A lookup offered in that time gets no response. lk_ready returns high in the cycle after fill_done, and a hit causes no stall.
- R7: A refill for a tag that differs from the line's stored tag installs the new tag and leaves only the fetched sub-block valid in that line.
- R8: A refill for a line whose tag already matches sets the fetched sub-block valid and keeps the other sub-blocks' valid bits and data.
- R9: fill_done while no refill is outstanding changes no tag, valid bit or data.
- R10: Lines are independent: filling one line never makes a lookup of another line hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 16 | Lookup address |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 8 | Stored word on a hit |
| fill_req | output | 1 | Refill outstanding |
| fill_tag | output | 8 | Tag of requested sub-block |
| fill_line | output | 4 | Line index of requested sub-block |
| fill_sub | output | 2 | Sub-block index requested |
| fill_done | input | 1 | Refill completion pulse |
| fill_data | input | 8 | Word returned with completion |

## Verification
The hardest case to reach from the ports is a line whose tag matches while the addressed sub-block is invalid and some of its siblings are valid. The mirror case is a tag replacement in a line that still holds valid sub-blocks under the old tag. Random addresses spread over a full tag space almost never produce either. The random stimulus therefore draws tags from a pool of four and line indices from a pool of four, so that partial lines and tag conflicts happen often. Directed sequences first build these two cases on purpose, then probe the sibling sub-blocks to show that they were kept or dropped.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;

    localparam int ADDR_W = 16;
    localparam int OFF_W  = 2;
    localparam int SUB_W  = 2;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 8;
    localparam int TAG_W  = ADDR_W - IDX_W - SUB_W - OFF_W;
    localparam int NSUB   = 1 << SUB_W;
    localparam int NLINE  = 1 << IDX_W;
    localparam int DEPTH  = NLINE * NSUB;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [SUB_W-1:0]  sub_t;
    typedef logic [NSUB-1:0]   vmask_t;
    typedef logic [DATA_W-1:0] word_t;

    // field order follows the address bit order, MSB first
    typedef struct packed {
        tag_t             tag;
        idx_t             idx;
        sub_t             sub;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef struct packed {
        tag_t tag;
        idx_t idx;
        sub_t sub;
        logic fresh;   // tag differs from stored one
    } fill_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} fstate_t;

    function automatic vmask_t sub_mask(input sub_t s);
        return vmask_t'(1) << s;
    endfunction

    function automatic vmask_t merge_valid(input vmask_t old, input sub_t s,
                                           input logic fresh);
        return fresh ? sub_mask(s) : (old | sub_mask(s));
    endfunction

endpackage

// File: rtl/sector_cache_tags.sv
module sector_cache_tags
    import sector_cache_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   rd_idx,
    output tag_t   rd_tag,
    output vmask_t rd_vld,
    input  logic   upd_en,
    input  fill_t  upd
);

    tag_t   tag_q [NLINE];
    vmask_t vld_q [NLINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINE; i++) begin
                vld_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else if (upd_en) begin
            vld_q[upd.idx] <= merge_valid(vld_q[upd.idx], upd.sub, upd.fresh);
            if (upd.fresh)
                tag_q[upd.idx] <= upd.tag;
        end
    end

    assign rd_tag = tag_q[rd_idx];
    assign rd_vld = vld_q[rd_idx];

endmodule

// File: rtl/sector_cache_data.sv
module sector_cache_data
    import sector_cache_pkg::*;
(
    input  logic  clk,
    input  idx_t  rd_idx,
    input  sub_t  rd_sub,
    output word_t rd_word,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  sub_t  wr_sub,
    input  word_t wr_word
);

    localparam int PTR_W = IDX_W + SUB_W;

    word_t mem_q [DEPTH];

    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    assign rd_ptr = {rd_idx, rd_sub};
    assign wr_ptr = {wr_idx, wr_sub};

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_ptr] <= wr_word;
    end

    assign rd_word = mem_q[rd_ptr];

endmodule

// File: rtl/sector_cache_fill.sv
module sector_cache_fill
    import sector_cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  fill_t start_info,
    input  logic  fill_done,
    output logic  busy,
    output fill_t pend,
    output logic  upd_en
);

    fstate_t state_q;
    fill_t   pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_FILL;
                    pend_q  <= start_info;
                end
                ST_FILL: if (fill_done) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q == ST_FILL);
    assign pend   = pend_q;
    assign upd_en = busy && fill_done;

endmodule

// File: rtl/sector_cache.sv
module sector_cache
    import sector_cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [IDX_W-1:0]  fill_line,
    output logic [SUB_W-1:0]  fill_sub,
    input  logic              fill_done,
    input  logic [DATA_W-1:0] fill_data
);

    addr_t  la;
    tag_t   rd_tag;
    vmask_t rd_vld;
    word_t  rd_word;
    logic   busy, accept, tag_eq, hit_c, upd_en;
    fill_t  req_info, pend;

    assign la = addr_t'(lk_addr);

    sector_cache_tags tags_i (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (la.idx),
        .rd_tag (rd_tag),
        .rd_vld (rd_vld),
        .upd_en (upd_en),
        .upd    (pend)
    );

    sector_cache_data data_i (
        .clk     (clk),
        .rd_idx  (la.idx),
        .rd_sub  (la.sub),
        .rd_word (rd_word),
        .wr_en   (upd_en),
        .wr_idx  (pend.idx),
        .wr_sub  (pend.sub),
        .wr_word (fill_data)
    );

    assign lk_ready = !busy;
    assign accept   = lk_valid && lk_ready;
    assign tag_eq   = (rd_tag == la.tag);
    assign hit_c    = tag_eq && rd_vld[la.sub];

    always_comb begin
        req_info.tag   = la.tag;
        req_info.idx   = la.idx;
        req_info.sub   = la.sub;
        req_info.fresh = !tag_eq;
    end

    sector_cache_fill fill_i (
        .clk        (clk),
        .rst        (rst),
        .start      (accept && !hit_c),
        .start_info (req_info),
        .fill_done  (fill_done),
        .busy       (busy),
        .pend       (pend),
        .upd_en     (upd_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && hit_c;
            rsp_data  <= rd_word;
        end
    end

    assign fill_req  = busy;
    assign fill_tag  = pend.tag;
    assign fill_line = pend.idx;
    assign fill_sub  = pend.sub;

endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk
    import sector_cache_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             fill_req,
    input logic [TAG_W-1:0] fill_tag,
    input logic [IDX_W-1:0] fill_line,
    input logic [SUB_W-1:0] fill_sub,
    input logic             fill_done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lk_ready && !fill_req && !rsp_valid));

    // R3
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> rsp_valid);

    // R3
    rsp_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid && lk_ready));

    // R5
    miss_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> fill_req);

    // R5
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_line)
                                      && $stable(fill_sub) && $stable(fill_tag)));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !lk_ready);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_done) |=> (lk_ready && !fill_req));

endmodule

bind sector_cache sector_cache_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .fill_req  (fill_req),
    .fill_tag  (fill_tag),
    .fill_line (fill_line),
    .fill_sub  (fill_sub),
    .fill_done (fill_done)
);

// File: tb/sector_cache_tb_top.sv
`timescale 1ns/1ps
module sector_cache_tb_top;
    import sector_cache_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_ready, rsp_valid, rsp_hit, fill_req;
    logic [DATA_W-1:0] rsp_data;
    logic [TAG_W-1:0]  fill_tag;
    logic [IDX_W-1:0]  fill_line;
    logic [SUB_W-1:0]  fill_sub;
    logic              fill_done = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    sector_cache dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .fill_req(fill_req), .fill_tag(fill_tag),
        .fill_line(fill_line), .fill_sub(fill_sub), .fill_done(fill_done),
        .fill_data(fill_data)
    );

    // reference state
    logic [TAG_W-1:0]  m_tag [NLINE];
    logic [NSUB-1:0]   m_vld [NLINE];
    logic [DATA_W-1:0] m_dat [DEPTH];

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i,
                                             input int s, input int o);
        return {TAG_W'(t), IDX_W'(i), SUB_W'(s), OFF_W'(o)};
    endfunction

    function automatic bit exp_hit(input logic [ADDR_W-1:0] a);
        addr_t f = addr_t'(a);
        return (m_tag[f.idx] == f.tag) && m_vld[f.idx][f.sub];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NLINE; i++) begin
            m_tag[i] = '0;
            m_vld[i] = '0;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one lookup; on a miss, serve the refill after 'dly' cycles
    task automatic lookup(input logic [ADDR_W-1:0] a, input int dly,
                          input bit probe, input logic [DATA_W-1:0] d);
        addr_t f = addr_t'(a);
        bit    h = exp_hit(a);
        int    p = {f.idx, f.sub};
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check("R3 rsp_valid", 32'(rsp_valid), 1);
        check("R3 rsp_hit", 32'(rsp_hit), 32'(h));
        if (h) begin
            check("R4 rsp_data", 32'(rsp_data), 32'(m_dat[p]));
            check("R6 no stall on hit", 32'(lk_ready), 1);
        end else begin
            check("R5 fill_req", 32'(fill_req), 1);
            check("R5 fill_tag", 32'(fill_tag), 32'(f.tag));
            check("R5 fill_line", 32'(fill_line), 32'(f.idx));
            check("R5 fill_sub", 32'(fill_sub), 32'(f.sub));
            check("R6 stalled", 32'(lk_ready), 0);
            for (int k = 0; k < dly; k++) begin
                if (probe) lk_valid = 1'b1;
                lk_addr = ADDR_W'($urandom);
                @(negedge clk);
                lk_valid = 1'b0;
                if (probe) check("R6 stalled lookup ignored", 32'(rsp_valid), 0);
                check("R5 fill_line held", 32'(fill_line), 32'(f.idx));
            end
            fill_done = 1'b1;
            fill_data = d;
            @(negedge clk);
            fill_done = 1'b0;
            check("R6 ready after fill", 32'(lk_ready), 1);
            check("R6 fill_req drop", 32'(fill_req), 0);
            if (m_tag[f.idx] != f.tag) begin
                m_tag[f.idx] = f.tag;
                m_vld[f.idx] = '0;
            end
            m_vld[f.idx][f.sub] = 1'b1;
            m_dat[p] = d;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 lk_ready", 32'(lk_ready), 1);
        check("R1 fill_req", 32'(fill_req), 0);
        check("R1 rsp_valid", 32'(rsp_valid), 0);

        // R2 offset ignored, R4 data returned
        lookup(mk(5, 3, 1, 0), 2, 1, 8'h11);
        lookup(mk(5, 3, 1, 3), 0, 0, 8'h00);
        // R3 tag match but sub invalid -> miss; R8 sibling kept
        lookup(mk(5, 3, 2, 1), 1, 0, 8'h22);
        lookup(mk(5, 3, 1, 2), 0, 0, 8'h00);
        lookup(mk(5, 3, 2, 0), 0, 0, 8'h00);
        // R7 tag replacement drops siblings
        lookup(mk(6, 3, 2, 0), 0, 1, 8'h33);
        lookup(mk(6, 3, 1, 0), 3, 1, 8'h44);
        lookup(mk(6, 3, 2, 0), 0, 0, 8'h00);
        // R10 another line is independent
        lookup(mk(6, 4, 2, 0), 0, 0, 8'h55);
        // R9 stray completion while idle
        @(negedge clk);
        fill_done = 1'b1;
        fill_data = 8'hEE;
        @(negedge clk);
        fill_done = 1'b0;
        check("R9 stray fill no request", 32'(fill_req), 0);
        lookup(mk(6, 3, 2, 0), 0, 0, 8'h00);   // R9 data unchanged: 33
        check("R9 data kept", 32'(rsp_data), 32'h33);
        lookup(mk(6, 9, 0, 0), 0, 0, 8'h66);   // R9 line 9 still empty

        // constrained random over a narrow tag and line pool
        for (int n = 0; n < 400; n++) begin
            lookup(mk($urandom_range(3), $urandom_range(3), $urandom_range(3),
                      $urandom_range(3)),
                   $urandom_range(3), bit'($urandom_range(1)),
                   DATA_W'($urandom));
        end

        // R1 reset mid-run clears all valid bits
        lookup(mk(7, 2, 3, 0), 0, 0, 8'h77);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 ready after reset", 32'(lk_ready), 1);
        lookup(mk(7, 2, 3, 0), 0, 0, 8'h78);   // expected miss (R1)

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule